// File: doc/BRIEF.md
# System configuration register bank

This block is a small bank of 32-bit configuration registers reached over an APB-style bus (select, enable, write, address, write data, read data). It keeps the selection of which memory appears at address zero, a one-way flag that turns memory protection on for good, a control word for an analog voltage reference that software can freeze, and sixteen 4-bit fields that pick which GPIO port drives each external interrupt line. The remap choice and the sixteen port fields leave the block as plain output ports.

Two reset inputs are used. The system reset clears or loads every register. The peripheral reset clears only the interrupt-source fields. The remap selection, the protection flag and the reference word keep their values through it. After a system reset the remap selection takes the boot-pin mode. Memory protection can only be switched on (its disable flag cleared) by software, and only a system reset switches it off again. Once software sets the lock bit in the reference word, that word cannot be changed until the next system reset.

A write takes effect on the clock edge where select, enable and write are all high. Read data is combinational from the registers while select is high and is zero otherwise.

Top module: `sys_cfg_bank`

## Requirements
- R1: Registers answer only at the exact byte addresses 0x00 (remap), 0x04 (protection mode), 0x08, 0x0C, 0x10 and 0x14 (interrupt sources for lines 0-3, 4-7, 8-11, 12-15) and 0x20 (reference control). A write commits only on a clock edge where sel, en and wr are all 1.
- R2: At 0x00, bits 9:8 always read the live boot_mode input (00 main flash, 01 system flash, 11 SRAM, 10 reserved), and writes to them are ignored.
- R3: At 0x00, bits 1:0 can be read and written and drive remap_sel. A system reset loads them from boot_mode, and a peripheral reset leaves them unchanged.
- R4: Bit 0 at 0x04 (protection-disable flag) is 1 after a system reset. Writing 0 clears it. Writing 1 has no effect. A peripheral reset does not set it.
- R5: Bit 31 at 0x20 is a lock bit that software sets by writing 1. While it is 1, writes to 0x20 change nothing, and only a system reset clears it.
- R6: At 0x20, bit 30 reads the live ref_ready input. Bit 8 (buffer enable), bits 5:4 (pad select: 00 none, 01 pad A, 10 pad B, 11 both) and bit 0 (reference enable) can be read and written while unlocked, and they reset to 0.
- R7: Line n's 4-bit source field sits in register 0x08 + 4*(n/4) at bits 4*(n%4)+3 : 4*(n%4) and is output on line_src[4n+3:4n]. Every field resets to 0000 on either reset.
- R8: Source codes 0000 to 0100 (ports A to E) are accepted for every line. Code 0101 (port H) is accepted only for lines 0, 1, 9 and 10. Any other code leaves that one field unchanged while the other fields of the same write still update.
- R9: Reads of any other address, including non-word-aligned ones, return 0, and writes there change nothing.
- R10: Reserved bits of every register read as 0 and ignore written ones.
- R11: rdata is 0 while sel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_sys_n | input | 1 | System reset, active low, synchronous |
| rst_per_n | input | 1 | Peripheral reset, active low, synchronous |
| sel | input | 1 | Bus select |
| en | input | 1 | Bus access-phase enable |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| boot_mode | input | 2 | Boot-pin mode |
| ref_ready | input | 1 | Voltage reference ready status |
| remap_sel | output | 2 | Selected memory at address zero |
| line_src | output | 64 | Sixteen 4-bit port-select fields, line 0 in the low bits |

## Verification
The assertions are checked on every clock edge and cover the following rules:
- the protection flag never goes from 0 back to 1 outside a system reset;
- a locked reference word never changes;
- a stored source field never holds a code that is reserved for its line;
- unmapped reads return zero;
- a peripheral reset clears the line fields but keeps the remap selection.

Only the bench's scenarios can show the rest:
- the exact bit layout of every register;
- that a rejected code leaves the neighbouring fields of the same write free to update;
- that the reset value of the remap selection follows boot_mode;
- that a setup phase without enable writes nothing.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;

    localparam int unsigned OFS_REMAP    = 32'h00;
    localparam int unsigned OFS_PMODE    = 32'h04;
    localparam int unsigned OFS_SRC_BASE = 32'h08;
    localparam int unsigned OFS_REF      = 32'h20;

    localparam int unsigned BOOT_LO      = 8;
    localparam int unsigned REF_LOCK_BIT = 31;
    localparam int unsigned REF_RDY_BIT  = 30;
    localparam int unsigned REF_BUF_BIT  = 8;
    localparam int unsigned REF_PAD_LO   = 4;
    localparam int unsigned REF_EN_BIT   = 0;

    localparam int unsigned SRC_LAST_COMMON = 4;
    localparam int unsigned SRC_PORT_H      = 5;

    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_REMAP,
        SLOT_PMODE,
        SLOT_SRC,
        SLOT_REF
    } slot_e;

    typedef struct packed {
        logic [1:0] remap;
        logic       fw_dis;
        logic       lock;
        logic       buf_en;
        logic [1:0] pad;
        logic       ref_en;
    } sys_state_t;

    typedef struct packed {
        logic [1:0] remap;
        logic       fw_dis;
        logic       lock;
        logic       buf_en;
        logic [1:0] pad;
        logic       ref_en;
    } sys_wr_t;

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
    import sys_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned N_SRC_REGS = 4,
    localparam int unsigned IDX_W     = (N_SRC_REGS > 1) ? $clog2(N_SRC_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output slot_e             slot,
    output logic [IDX_W-1:0]  src_idx
);

    always_comb begin
        slot    = SLOT_NONE;
        src_idx = '0;
        if (addr == ADDR_W'(OFS_REMAP)) begin
            slot = SLOT_REMAP;
        end else if (addr == ADDR_W'(OFS_PMODE)) begin
            slot = SLOT_PMODE;
        end else if (addr == ADDR_W'(OFS_REF)) begin
            slot = SLOT_REF;
        end
        for (int i = 0; i < int'(N_SRC_REGS); i++) begin
            if (addr == ADDR_W'(OFS_SRC_BASE + 4 * i)) begin
                slot    = SLOT_SRC;
                src_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cfg_sys_regs.sv
module cfg_sys_regs
    import sys_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_sys_n,
    input  logic [1:0] boot_mode,
    input  logic       wr_remap,
    input  logic       wr_pmode,
    input  logic       wr_ref,
    input  sys_wr_t    wfields,
    output sys_state_t state
);

    sys_state_t cur_q;
    sys_state_t nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr_remap) begin
            nxt_d.remap = wfields.remap;
        end
        if (wr_pmode && !wfields.fw_dis) begin
            nxt_d.fw_dis = 1'b0;
        end
        if (wr_ref && !cur_q.lock) begin
            nxt_d.lock   = wfields.lock;
            nxt_d.buf_en = wfields.buf_en;
            nxt_d.pad    = wfields.pad;
            nxt_d.ref_en = wfields.ref_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            cur_q <= '{remap: boot_mode, fw_dis: 1'b1, lock: 1'b0,
                       buf_en: 1'b0, pad: 2'b00, ref_en: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state = cur_q;

    // R4
    fw_one_way_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        !cur_q.fw_dis |=> !cur_q.fw_dis);

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        cur_q.lock |=> $stable({cur_q.lock, cur_q.buf_en, cur_q.pad, cur_q.ref_en}));

endmodule

// File: rtl/cfg_line_src.sv
module cfg_line_src
    import sys_cfg_pkg::*;
#(
    parameter int unsigned N_LINES     = 16,
    parameter int unsigned SRC_W       = 4,
    parameter int unsigned FPR         = 4,
    parameter logic [N_LINES-1:0] H_LINE_MASK = 16'h0603,
    localparam int unsigned N_REGS     = N_LINES / FPR,
    localparam int unsigned IDX_W      = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              idx,
    input  logic [FPR-1:0][SRC_W-1:0]     wfields,
    output logic [FPR-1:0][SRC_W-1:0]     rfields,
    output logic [N_LINES-1:0][SRC_W-1:0] src
);

    logic [N_LINES-1:0][SRC_W-1:0] src_q;
    logic [N_LINES-1:0][SRC_W-1:0] src_d;

    function automatic logic code_ok(input logic [SRC_W-1:0] code, input logic h_ok);
        return (code <= SRC_W'(SRC_LAST_COMMON)) ||
               ((code == SRC_W'(SRC_PORT_H)) && h_ok);
    endfunction

    always_comb begin
        src_d = src_q;
        for (int l = 0; l < int'(N_LINES); l++) begin
            if (wr_en && (idx == IDX_W'(l / int'(FPR))) &&
                code_ok(wfields[l % int'(FPR)], H_LINE_MASK[l])) begin
                src_d[l] = wfields[l % int'(FPR)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src_d;
        end
    end

    always_comb begin
        rfields = '0;
        for (int l = 0; l < int'(N_LINES); l++) begin
            if (idx == IDX_W'(l / int'(FPR))) begin
                rfields[l % int'(FPR)] = src_q[l];
            end
        end
    end

    assign src = src_q;

    for (genvar g = 0; g < int'(N_LINES); g++) begin : g_line_chk
        // R8
        code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_q[g] <= SRC_W'(SRC_PORT_H)) &&
            ((src_q[g] != SRC_W'(SRC_PORT_H)) || H_LINE_MASK[g]));
    end

endmodule

// File: rtl/sys_cfg_bank.sv
module sys_cfg_bank
    import sys_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned N_LINES = 16,
    parameter int unsigned SRC_W   = 4,
    parameter int unsigned FPR     = 4,
    parameter logic [N_LINES-1:0] H_LINE_MASK = 16'h0603,
    localparam int unsigned N_REGS = N_LINES / FPR,
    localparam int unsigned IDX_W  = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_sys_n,
    input  logic                       rst_per_n,
    input  logic                       sel,
    input  logic                       en,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic [1:0]                 boot_mode,
    input  logic                       ref_ready,
    output logic [1:0]                 remap_sel,
    output logic [N_LINES*SRC_W-1:0]   line_src
);

    slot_e                     slot;
    logic [IDX_W-1:0]          src_idx;
    logic                      we;
    logic                      line_rst_n;
    sys_wr_t                   sys_wr;
    sys_state_t                sys_st;
    logic [FPR-1:0][SRC_W-1:0] src_wr_fields;
    logic [FPR-1:0][SRC_W-1:0] src_rd_fields;
    logic [N_LINES-1:0][SRC_W-1:0] src_all;

    cfg_addr_dec #(.ADDR_W(ADDR_W), .N_SRC_REGS(N_REGS)) u_dec (
        .addr    (addr),
        .slot    (slot),
        .src_idx (src_idx)
    );

    assign we         = sel && en && wr;
    assign line_rst_n = rst_sys_n && rst_per_n;

    assign sys_wr.remap  = wdata[1:0];
    assign sys_wr.fw_dis = wdata[0];
    assign sys_wr.lock   = wdata[REF_LOCK_BIT];
    assign sys_wr.buf_en = wdata[REF_BUF_BIT];
    assign sys_wr.pad    = wdata[REF_PAD_LO +: 2];
    assign sys_wr.ref_en = wdata[REF_EN_BIT];

    cfg_sys_regs u_sys (
        .clk       (clk),
        .rst_sys_n (rst_sys_n),
        .boot_mode (boot_mode),
        .wr_remap  (we && (slot == SLOT_REMAP)),
        .wr_pmode  (we && (slot == SLOT_PMODE)),
        .wr_ref    (we && (slot == SLOT_REF)),
        .wfields   (sys_wr),
        .state     (sys_st)
    );

    assign src_wr_fields = wdata[FPR*SRC_W-1:0];

    cfg_line_src #(
        .N_LINES(N_LINES), .SRC_W(SRC_W), .FPR(FPR), .H_LINE_MASK(H_LINE_MASK)
    ) u_lines (
        .clk     (clk),
        .rst_n   (line_rst_n),
        .wr_en   (we && (slot == SLOT_SRC)),
        .idx     (src_idx),
        .wfields (src_wr_fields),
        .rfields (src_rd_fields),
        .src     (src_all)
    );

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (slot)
                SLOT_REMAP: begin
                    rdata[BOOT_LO +: 2] = boot_mode;
                    rdata[1:0]          = sys_st.remap;
                end
                SLOT_PMODE: rdata[0] = sys_st.fw_dis;
                SLOT_SRC:   rdata[FPR*SRC_W-1:0] = src_rd_fields;
                SLOT_REF: begin
                    rdata[REF_LOCK_BIT]      = sys_st.lock;
                    rdata[REF_RDY_BIT]       = ref_ready;
                    rdata[REF_BUF_BIT]       = sys_st.buf_en;
                    rdata[REF_PAD_LO +: 2]   = sys_st.pad;
                    rdata[REF_EN_BIT]        = sys_st.ref_en;
                end
                default: rdata = '0;
            endcase
        end
    end

    assign remap_sel = sys_st.remap;
    assign line_src  = src_all;

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        (sel && (slot == SLOT_NONE)) |-> (rdata == '0));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        !sel |-> (rdata == '0));

    // R3
    per_reset_keep_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        (!rst_per_n && !(we && (slot == SLOT_REMAP))) |=> $stable(remap_sel));

    // R7
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
        !rst_per_n |=> (line_src == '0));

endmodule

// File: tb/sim_sys_cfg_bank.sv
`timescale 1ns/1ps
module sim_sys_cfg_bank;

    logic        clk = 1'b0;
    logic        rst_sys_n = 1'b0;
    logic        rst_per_n = 1'b1;
    logic        sel = 1'b0, en = 1'b0, wr = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  boot_mode = 2'b01;
    logic        ref_ready = 1'b1;
    logic [1:0]  remap_sel;
    logic [63:0] line_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sys_cfg_bank u0 (
        .clk(clk), .rst_sys_n(rst_sys_n), .rst_per_n(rst_per_n),
        .sel(sel), .en(en), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
        .boot_mode(boot_mode), .ref_ready(ref_ready),
        .remap_sel(remap_sel), .line_src(line_src)
    );

    typedef struct packed {
        logic        do_wr;
        logic [31:0] a;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 32'h00, 32'h0000_0000, 32'h0000_0101}, // R2 R3 reset load
        '{1'b1, 32'h00, 32'hFFFF_FFF3, 32'h0000_0103}, // R10 R2
        '{1'b1, 32'h00, 32'h0000_0200, 32'h0000_0100}, // R2 R3
        '{1'b0, 32'h04, 32'h0000_0000, 32'h0000_0001}, // R4 reset
        '{1'b1, 32'h04, 32'hFFFF_FFFF, 32'h0000_0001}, // R4 R10
        '{1'b1, 32'h04, 32'h0000_0000, 32'h0000_0000}, // R4 clear
        '{1'b1, 32'h04, 32'h0000_0001, 32'h0000_0000}, // R4 no re-set
        '{1'b0, 32'h20, 32'h0000_0000, 32'h4000_0000}, // R6
        '{1'b1, 32'h20, 32'h0000_0131, 32'h4000_0131}, // R6
        '{1'b1, 32'h20, 32'h3FFF_FFFF, 32'h4000_0131}, // R10 R6
        '{1'b1, 32'h20, 32'h0000_0020, 32'h4000_0020}, // R6 pad B
        '{1'b1, 32'h08, 32'h0000_4321, 32'h0000_4321}, // R7
        '{1'b1, 32'h08, 32'h0000_5555, 32'h0000_4355}, // R8
        '{1'b1, 32'h08, 32'hFFFF_0000, 32'h0000_0000}, // R10
        '{1'b1, 32'h08, 32'h0000_6789, 32'h0000_0000}, // R8 reserved
        '{1'b1, 32'h0C, 32'h0000_4444, 32'h0000_4444}, // R7
        '{1'b1, 32'h0C, 32'h0000_5555, 32'h0000_4444}, // R8
        '{1'b1, 32'h10, 32'h0000_5555, 32'h0000_0550}, // R8
        '{1'b1, 32'h14, 32'h0000_5432, 32'h0000_0432}, // R8
        '{1'b1, 32'h18, 32'hFFFF_FFFF, 32'h0000_0000}, // R9
        '{1'b1, 32'h24, 32'h0000_FFFF, 32'h0000_0000}, // R9
        '{1'b0, 32'h02, 32'h0000_0000, 32'h0000_0000}, // R9 unaligned
        '{1'b0, 32'h100, 32'h0000_0000, 32'h0000_0000} // R9 R1
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1'b1; en = 1'b0; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); en = 1'b1;
        @(negedge clk); sel = 1'b0; en = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1'b1; en = 1'b0; wr = 1'b0; addr = a;
        @(negedge clk); en = 1'b1;
        #1 d = rdata;
        @(negedge clk); sel = 1'b0; en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_sys_n = 1'b1;
        @(negedge clk);
        check("R7 reset lines", line_src, 64'h0);
        check("R3 reset remap", {62'h0, remap_sel}, 64'h1);
        check("R11 idle rdata", {32'h0, rdata}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].do_wr) bus_write(VECS[i].a, VECS[i].d);
            bus_read(VECS[i].a, rd);
            check($sformatf("R1 vector %0d", i), {32'h0, rd}, {32'h0, VECS[i].exp});
        end

        check("R7 line outputs", line_src, 64'h0432_0550_4444_0000);
        check("R3 remap port", {62'h0, remap_sel}, 64'h0);

        // R1: setup phase without enable writes nothing
        @(negedge clk); sel = 1'b1; wr = 1'b1; en = 1'b0; addr = 32'h00; wdata = 32'h3;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
        @(negedge clk);
        check("R1 no write without enable", {62'h0, remap_sel}, 64'h0);

        // R5: lock freezes the reference word
        bus_write(32'h20, 32'h8000_0101);
        bus_read(32'h20, rd);
        check("R5 lock set", {32'h0, rd}, {32'h0, 32'hC000_0101});
        bus_write(32'h20, 32'h0000_0030);
        bus_read(32'h20, rd);
        check("R5 locked write ignored", {32'h0, rd}, {32'h0, 32'hC000_0101});
        ref_ready = 1'b0;
        bus_read(32'h20, rd);
        check("R6 ready live", {32'h0, rd}, {32'h0, 32'h8000_0101});

        // peripheral reset
        boot_mode = 2'b11;
        @(negedge clk); rst_per_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_per_n = 1'b1;
        check("R7 peripheral reset clears lines", line_src, 64'h0);
        check("R3 remap kept", {62'h0, remap_sel}, 64'h0);
        bus_read(32'h00, rd);
        check("R2 boot live", {32'h0, rd}, {32'h0, 32'h0000_0300});
        bus_read(32'h04, rd);
        check("R4 peripheral reset keeps flag", {32'h0, rd}, 64'h0);
        bus_read(32'h20, rd);
        check("R5 lock survives peripheral reset", {32'h0, rd}, {32'h0, 32'h8000_0101});

        // system reset
        @(negedge clk); rst_sys_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_sys_n = 1'b1;
        check("R3 remap from boot", {62'h0, remap_sel}, 64'h3);
        bus_read(32'h04, rd);
        check("R4 system reset sets flag", {32'h0, rd}, 64'h1);
        bus_read(32'h20, rd);
        check("R6 ref reset", {32'h0, rd}, 64'h0);
        bus_write(32'h20, 32'h0000_0001);
        bus_read(32'h20, rd);
        check("R5 unlocked after system reset", {32'h0, rd}, 64'h1);

        finish_run();
    end

endmodule